// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit turns a 16-bit offset into a 20-bit physical address by adding it to one of four 16-bit segment bases: code, stack, data and extra. Each base is the segment register value shifted left by four bit positions with zeros filled in. The segment is not always named by the caller. The unit chooses a default from the kind of access and, for ordinary data accesses, from the base register that forms the offset. An explicit override can then replace that default, except where a rule below says it cannot.

The unit also holds the instruction pointer, and instruction fetches are formed from the code segment and that pointer. A control-transfer input updates the pointer at the next clock edge. A near transfer loads a new pointer. A far transfer loads the pointer and the code segment together. A relative transfer adds a signed displacement to the pointer. A separate write port loads any segment register. The physical address and the chosen segment index are combinational in the current register state. Register updates take effect at the rising clock edge.

Top module: `seg_addr_gen`

## Requirements
- R1: `physAddr` equals (selected segment value × 16 + effective offset) modulo 2^20. For example, segment 0x0010 with offset 0x0100 gives 0x00200, and segment 0xFFFF with offset 0xFFFF wraps to 0x0FFEF.
- R2: When `accKind` = 0 (instruction fetch), the unit uses the code segment (`segUsed` = 0) and the instruction pointer as the offset. `offset`, `ovrEn` and `ovrSel` have no effect.
- R3: When `accKind` = 1 (data access) and no override is present, a `baseReg` code of 3 (stack pointer) or 4 (frame pointer) selects the stack segment (`segUsed` = 1). Every other code, including 0, 1 and 2 (the general index/base registers), selects the data segment (`segUsed` = 2).
- R4: When `accKind` = 2 (block-move source), the default segment is the data segment (2). When `accKind` = 3 (block-move destination), the unit always uses the extra segment (3), whatever `ovrEn` and `ovrSel` say.
- R5: When `ovrEn` = 1 and `accKind` is 1 or 2, the unit uses segment `ovrSel` (0 code, 1 stack, 2 data, 3 extra).
- R6: When `segWrEn` = 1, segment `segWrSel` takes `segWrData` at the clock edge. The new value shows in addresses from the following cycle on.
- R7: When `xferKind` = 1 (near), `ipOut` becomes `xferIp` after the edge and the code segment is unchanged.
- R8: When `xferKind` = 2 (far), the code segment becomes `xferSeg` and `ipOut` becomes `xferIp` at the same edge. This takes priority over a segment write to the code segment in the same cycle.
- R9: When `xferKind` = 3 (relative), `ipOut` becomes `ipOut + xferIp` modulo 2^16, with `xferIp` taken as a signed displacement.
- R10: After reset, the code segment is 0xFFFF and the stack, data and extra segments and the instruction pointer are 0. The first fetch is therefore at 0xFFFF0.
- R11: When `xferKind` = 0, the instruction pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| accKind | input | 2 | Access kind: 0 fetch, 1 data, 2 block source, 3 block destination |
| baseReg | input | 3 | Base register code for data accesses; 3 and 4 are stack based |
| offset | input | 16 | Offset for non-fetch accesses |
| ovrEn | input | 1 | Segment override present |
| ovrSel | input | 2 | Override segment index |
| segWrEn | input | 1 | Segment register write strobe |
| segWrSel | input | 2 | Segment register to write |
| segWrData | input | 16 | Segment write value |
| xferKind | input | 2 | Transfer: 0 none, 1 near, 2 far, 3 relative |
| xferIp | input | 16 | New pointer, or signed displacement for relative |
| xferSeg | input | 16 | New code segment for far transfer |
| physAddr | output | 20 | Physical address |
| segUsed | output | 2 | Index of the segment used |
| ipOut | output | 16 | Current instruction pointer |
| csOut | output | 16 | Current code segment |

## Verification
Two cases are the hardest to reach from the ports. The first is a far transfer and a code-segment write arriving in the same cycle. The second is a block-move destination that carries an override. Random stimulus rarely lines up either case with a check afterwards, so both are driven directly, and a fetch follows each so that the surviving code segment can be seen. Address wrap above 2^20 needs a segment near 0xFFFF loaded through the write port before the access, so a directed sequence loads it. The three segment/offset pairs that all land on 0x06700 are reached through three different selection paths: base register, block destination and frame pointer. Constrained random cycles then mix every access kind, override and transfer against a bench model.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [1:0] {SEG_CODE = 2'd0, SEG_STACK = 2'd1, SEG_DATA = 2'd2, SEG_EXTRA = 2'd3} segIdx_e;
  typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_DATA = 2'd1, ACC_BLKSRC = 2'd2, ACC_BLKDST = 2'd3} accKind_e;
  typedef enum logic [1:0] {XFER_NONE = 2'd0, XFER_NEAR = 2'd1, XFER_FAR = 2'd2, XFER_REL = 2'd3} xferKind_e;
  localparam int NUM_SEGS = 4;
  localparam int BASE_W = 3;
  localparam logic [BASE_W-1:0] BASE_SP = 3'd3;
  localparam logic [BASE_W-1:0] BASE_BP = 3'd4;

  typedef struct packed {
    segIdx_e segSel;
    logic    useIp;
    logic    ipLoad;
    logic    ipRel;
    logic    csLoad;
  } ctrlStrobes_t;
endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import seg_addr_pkg::*;
(
  input  logic [1:0]        accKind,
  input  logic [BASE_W-1:0] baseReg,
  input  logic              ovrEn,
  input  logic [1:0]        ovrSel,
  input  logic [1:0]        xferKind,
  output ctrlStrobes_t      strobes
);
  accKind_e  acc;
  xferKind_e xk;
  segIdx_e   dflt;

  assign acc = accKind_e'(accKind);
  assign xk  = xferKind_e'(xferKind);

  always_comb begin
    unique case (acc)
      ACC_FETCH:  dflt = SEG_CODE;
      ACC_DATA:   dflt = (baseReg == BASE_SP || baseReg == BASE_BP) ? SEG_STACK : SEG_DATA;
      ACC_BLKSRC: dflt = SEG_DATA;
      default:    dflt = SEG_EXTRA;
    endcase
  end

  always_comb begin
    strobes.segSel = dflt;
    if (ovrEn && (acc == ACC_DATA || acc == ACC_BLKSRC))
      strobes.segSel = segIdx_e'(ovrSel);
    strobes.useIp  = (acc == ACC_FETCH);
    strobes.ipLoad = (xk == XFER_NEAR) || (xk == XFER_FAR);
    strobes.ipRel  = (xk == XFER_REL);
    strobes.csLoad = (xk == XFER_FAR);
  end
endmodule

// File: rtl/seg_addr_datapath.sv
module seg_addr_datapath
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter logic [SEG_W-1:0] CS_RESET = '1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            strobes,
  input  logic [OFF_W-1:0]        offset,
  input  logic                    segWrEn,
  input  logic [1:0]              segWrSel,
  input  logic [SEG_W-1:0]        segWrData,
  input  logic [OFF_W-1:0]        xferIp,
  input  logic [SEG_W-1:0]        xferSeg,
  output logic [SEG_W+SHIFT-1:0]  physAddr,
  output logic [1:0]              segUsed,
  output logic [OFF_W-1:0]        ipOut,
  output logic [SEG_W-1:0]        csOut
);
  localparam int ADDR_W = SEG_W + SHIFT;

  logic [SEG_W-1:0]  segQ [NUM_SEGS];
  logic [OFF_W-1:0]  ipQ;
  logic [OFF_W-1:0]  offEff;
  logic [ADDR_W-1:0] baseAddr;

  for (genvar i = 0; i < NUM_SEGS; i++) begin : g_seg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        segQ[i] <= (i == 0) ? CS_RESET : '0;
      else if (i == 0 && strobes.csLoad)
        segQ[i] <= xferSeg;
      else if (segWrEn && segWrSel == 2'(i))
        segQ[i] <= segWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ipQ <= '0;
    else if (strobes.ipLoad) ipQ <= xferIp;
    else if (strobes.ipRel)  ipQ <= ipQ + xferIp;
  end

  assign offEff   = strobes.useIp ? ipQ : offset;
  assign baseAddr = {segQ[strobes.segSel], {SHIFT{1'b0}}};
  assign physAddr = baseAddr + {{(ADDR_W-OFF_W){1'b0}}, offEff};
  assign segUsed  = strobes.segSel;
  assign ipOut    = ipQ;
  assign csOut    = segQ[0];
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter logic [SEG_W-1:0] CS_RESET = '1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             accKind,
  input  logic [2:0]             baseReg,
  input  logic [OFF_W-1:0]       offset,
  input  logic                   ovrEn,
  input  logic [1:0]             ovrSel,
  input  logic                   segWrEn,
  input  logic [1:0]             segWrSel,
  input  logic [SEG_W-1:0]       segWrData,
  input  logic [1:0]             xferKind,
  input  logic [OFF_W-1:0]       xferIp,
  input  logic [SEG_W-1:0]       xferSeg,
  output logic [SEG_W+SHIFT-1:0] physAddr,
  output logic [1:0]             segUsed,
  output logic [OFF_W-1:0]       ipOut,
  output logic [SEG_W-1:0]       csOut
);
  ctrlStrobes_t strobes;

  seg_addr_ctrl u_ctrl (
    .accKind(accKind), .baseReg(baseReg), .ovrEn(ovrEn), .ovrSel(ovrSel),
    .xferKind(xferKind), .strobes(strobes)
  );

  seg_addr_datapath #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .CS_RESET(CS_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .offset(offset),
    .segWrEn(segWrEn), .segWrSel(segWrSel), .segWrData(segWrData),
    .xferIp(xferIp), .xferSeg(xferSeg),
    .physAddr(physAddr), .segUsed(segUsed), .ipOut(ipOut), .csOut(csOut)
  );
endmodule

// File: rtl/seg_addr_gen_checker.sv
module seg_addr_gen_checker #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [1:0]             accKind,
  input logic [2:0]             baseReg,
  input logic                   ovrEn,
  input logic [1:0]             ovrSel,
  input logic                   segWrEn,
  input logic [1:0]             segWrSel,
  input logic [1:0]             xferKind,
  input logic [OFF_W-1:0]       xferIp,
  input logic [SEG_W-1:0]       xferSeg,
  input logic [SEG_W+SHIFT-1:0] physAddr,
  input logic [1:0]             segUsed,
  input logic [OFF_W-1:0]       ipOut,
  input logic [SEG_W-1:0]       csOut
);
  localparam int ADDR_W = SEG_W + SHIFT;

  assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    accKind == 2'd0 |-> (segUsed == 2'd0 &&
      physAddr == ADDR_W'({csOut, {SHIFT{1'b0}}} + {{(ADDR_W-OFF_W){1'b0}}, ipOut})));

  assert_stack_default_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accKind == 2'd1 && !ovrEn && (baseReg == 3'd3 || baseReg == 3'd4)) |-> segUsed == 2'd1);

  assert_blkdst_extra_R4: assert property (@(posedge clk) disable iff (!rstN)
    accKind == 2'd3 |-> segUsed == 2'd3);

  assert_override_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ovrEn && (accKind == 2'd1 || accKind == 2'd2)) |-> segUsed == ovrSel);

  assert_near_R7: assert property (@(posedge clk) disable iff (!rstN)
    (xferKind == 2'd1 && !(segWrEn && segWrSel == 2'd0)) |=> (ipOut == $past(xferIp) && $stable(csOut)));

  assert_far_R8: assert property (@(posedge clk) disable iff (!rstN)
    xferKind == 2'd2 |=> (ipOut == $past(xferIp) && csOut == $past(xferSeg)));

  assert_rel_R9: assert property (@(posedge clk) disable iff (!rstN)
    xferKind == 2'd3 |=> ipOut == OFF_W'($past(ipOut) + $past(xferIp)));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    xferKind == 2'd0 |=> $stable(ipOut));
endmodule

bind seg_addr_gen seg_addr_gen_checker #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_chk (
  .clk(clk), .rstN(rstN), .accKind(accKind), .baseReg(baseReg), .ovrEn(ovrEn), .ovrSel(ovrSel),
  .segWrEn(segWrEn), .segWrSel(segWrSel), .xferKind(xferKind), .xferIp(xferIp), .xferSeg(xferSeg),
  .physAddr(physAddr), .segUsed(segUsed), .ipOut(ipOut), .csOut(csOut)
);

// File: tb/seg_addr_gen_bench.sv
`timescale 1ns/1ps
module seg_addr_gen_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0]  accKind = '0;
  logic [2:0]  baseReg = '0;
  logic [15:0] offset = '0;
  logic        ovrEn = 1'b0;
  logic [1:0]  ovrSel = '0;
  logic        segWrEn = 1'b0;
  logic [1:0]  segWrSel = '0;
  logic [15:0] segWrData = '0;
  logic [1:0]  xferKind = '0;
  logic [15:0] xferIp = '0;
  logic [15:0] xferSeg = '0;
  logic [19:0] physAddr;
  logic [1:0]  segUsed;
  logic [15:0] ipOut;
  logic [15:0] csOut;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  logic [15:0] mSeg [4];
  logic [15:0] mIp;

  always #2 clk = ~clk;

  seg_addr_gen u_seg_addr_gen (.*);

  function automatic logic [19:0] expAddr(input logic [15:0] seg, input logic [15:0] off);
    return {seg, 4'h0} + {4'h0, off};
  endfunction

  function automatic logic [1:0] expSeg(input logic [1:0] acc, input logic [2:0] base,
                                        input logic oe, input logic [1:0] os);
    if (acc == 2'd0) return 2'd0;
    if (acc == 2'd3) return 2'd3;
    if (oe) return os;
    if (acc == 2'd2) return 2'd2;
    return (base == 3'd3 || base == 3'd4) ? 2'd1 : 2'd2;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] acc, input logic [2:0] base, input logic [15:0] off,
                      input logic oe, input logic [1:0] os,
                      input logic we, input logic [1:0] ws, input logic [15:0] wd,
                      input logic [1:0] xk, input logic [15:0] xi, input logic [15:0] xs,
                      input string req);
    logic [1:0] s;
    @(negedge clk);
    accKind = acc; baseReg = base; offset = off; ovrEn = oe; ovrSel = os;
    segWrEn = we; segWrSel = ws; segWrData = wd; xferKind = xk; xferIp = xi; xferSeg = xs;
    #1;
    s = expSeg(acc, base, oe, os);
    chk(req, "segUsed", 32'(segUsed), 32'(s));
    chk(req, "physAddr", 32'(physAddr), 32'(expAddr(mSeg[s], (acc == 2'd0) ? mIp : off)));
    chk(req, "ipOut", 32'(ipOut), 32'(mIp));
    chk(req, "csOut", 32'(csOut), 32'(mSeg[0]));
    @(posedge clk);
    if (we && !(xk == 2'd2 && ws == 2'd0)) mSeg[ws] = wd;
    if (xk == 2'd2) mSeg[0] = xs;
    if (xk == 2'd1 || xk == 2'd2) mIp = xi;
    else if (xk == 2'd3) mIp = mIp + xi;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failed++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mSeg[0] = 16'hFFFF; mSeg[1] = '0; mSeg[2] = '0; mSeg[3] = '0; mIp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R10: reset state, first fetch at 0xFFFF0
    step(2'd0, 3'd0, 16'h5555, 1'b1, 2'd2, 1'b0, 2'd0, 16'h0, 2'd0, 16'h0, 16'h0, "R10");
    chk("R10", "resetFetch", 32'(expAddr(16'hFFFF, 16'h0)), 32'h000FFFF0);
    // R6 + R1: data segment 0x0010, offset 0x0100 -> 0x00200
    step(2'd1, 3'd0, 16'h0, 1'b0, 2'd0, 1'b1, 2'd2, 16'h0010, 2'd0, 16'h0, 16'h0, "R6");
    step(2'd1, 3'd0, 16'h0100, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, 2'd0, 16'h0, 16'h0, "R1");
    chk("R1", "example200", 32'(physAddr), 32'h00200);
    // R3/R4: three aliases of 0x06700
    step(2'd1, 3'd1, 16'h0, 1'b0, 2'd0, 1'b1, 2'd2, 16'h0670, 2'd0, 16'h0, 16'h0, "R6");
    step(2'd1, 3'd1, 16'h0000, 1'b0, 2'd0, 1'b1, 2'd3, 16'h0300, 2'd0, 16'h0, 16'h0, "R3");
    chk("R1", "alias1", 32'(physAddr), 32'h06700);
    step(2'd3, 3'd0, 16'h3700, 1'b1, 2'd0, 1'b0, 2'd0, 16'h0, 2'd0, 16'h0, 16'h0, "R4");
    chk("R4", "alias2 override ignored", 32'(physAddr), 32'h06700);
    step(2'd1, 3'd4, 16'h6700, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, 2'd0, 16'h0, 16'h0, "R3");
    chk("R3", "alias3 frame ptr", 32'(physAddr), 32'h06700);
    step(2'd1, 3'd3, 16'h0010, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, 2'd0, 16'h0, 16'h0, "R3");
    step(2'd2, 3'd3, 16'h0010, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, 2'd0, 16'h0, 16'h0, "R4");
    // R5: override on data and block source
    step(2'd1, 3'd3, 16'h0020, 1'b1, 2'd3, 1'b0, 2'd0, 16'h0, 2'd0, 16'h0, 16'h0, "R5");
    step(2'd2, 3'd0, 16'h0020, 1'b1, 2'd0, 1'b0, 2'd0, 16'h0, 2'd0, 16'h0, 16'h0, "R5");
    // R1 wrap: data 0xFFFF + 0xFFFF -> 0x0FFEF
    step(2'd1, 3'd0, 16'h0, 1'b0, 2'd0, 1'b1, 2'd2, 16'hFFFF, 2'd0, 16'h0, 16'h0, "R6");
    step(2'd1, 3'd0, 16'hFFFF, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, 2'd0, 16'h0, 16'h0, "R1");
    chk("R1", "wrap", 32'(physAddr), 32'h0FFEF);
    // R7 near, R9 relative (negative), R11 hold, R2 fetch ignores offset/override
    step(2'd0, 3'd0, 16'h1111, 1'b1, 2'd3, 1'b0, 2'd0, 16'h0, 2'd1, 16'h0100, 16'h9999, "R7");
    step(2'd0, 3'd0, 16'h2222, 1'b1, 2'd2, 1'b0, 2'd0, 16'h0, 2'd3, 16'hFFF0, 16'h0, "R9");
    step(2'd0, 3'd0, 16'h3333, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, 2'd0, 16'h0, 16'h0, "R11");
    chk("R9", "relBack", 32'(ipOut), 32'h00F0);
    step(2'd0, 3'd0, 16'h0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, 2'd3, 16'hFF20, 16'h0, "R9");
    step(2'd0, 3'd0, 16'h0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, 2'd0, 16'h0, 16'h0, "R2");
    chk("R9", "relWrap", 32'(ipOut), 32'h0010);
    // R8: far transfer with a simultaneous code-segment write; far wins
    step(2'd0, 3'd0, 16'h0, 1'b0, 2'd0, 1'b1, 2'd0, 16'hAAAA, 2'd2, 16'h0010, 16'h0020, "R8");
    step(2'd0, 3'd0, 16'h0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, 2'd0, 16'h0, 16'h0, "R8");
    chk("R8", "farCs", 32'(csOut), 32'h0020);
    chk("R8", "farAddr", 32'(physAddr), 32'h00210);
    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] a, k;
      a = 2'($urandom_range(0, 3));
      k = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'd0;
      step(a, 3'($urandom_range(0, 7)), 16'($urandom), 1'($urandom), 2'($urandom),
           ($urandom_range(0, 4) == 0), 2'($urandom), 16'($urandom),
           k, 16'($urandom), 16'($urandom), "R1 random");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule